// File: doc/BRIEF.md
# Serial Control Port Slave with Register and FIFO Access

This block is the serial control port of a transceiver. An external master drives a chip-select (active low), a serial clock and a data line. The block runs on a fast system clock, passes the three serial inputs through two-flop synchronizers, and finds the serial clock edges in the system domain. Each frame framed by a low chip-select is one of two kinds. A configuration frame reads or writes one byte of a 25-entry register file. A FIFO stream moves whole bytes between the serial pins and an internal byte FIFO for as long as chip-select stays low.

The two-bit mode input picks the kind of frame, and the block samples it when chip-select falls. In burst transmit mode, incoming serial bytes are pushed into the FIFO, and the local side drains them through its pop port. In burst receive mode, the local side fills the FIFO through its push port, and the block shifts the bytes out on the serial output. Any other mode value gives a configuration frame. Both ends of the FIFO report underflow and overflow through sticky flags.

Top module: `ctl_port_slave`

## Requirements
- R1: After the active-low reset, every register reads 0x00, the FIFO is empty, both sticky flags are clear and the serial output enable is low.
- R2: A configuration frame sends its bits most significant first, each sampled on a rising serial clock edge. The first bit is the direction (1 = read, 0 = write), then seven address bits, then eight data bits.
- R3: A register write takes effect only once the sixteenth bit has been received. A later read of that address returns the written byte.
- R4: In a read frame, the register byte is driven on the serial output from the eighth falling serial clock edge onward. The output changes on falling edges only, so the master can sample it on rising edges.
- R5: A configuration frame that chip-select ends before its sixteenth bit changes no register.
- R6: A write to an address above 0x18 changes no register, and a read from such an address returns 0x00.
- R7: With mode 01 (burst transmit), every eight serial bits form one byte that is pushed into the FIFO, in arrival order and with no command byte. A local pop returns the bytes in that order, and local pushes are ignored during the stream.
- R8: With mode 10 (burst receive), the FIFO head is popped when chip-select falls, and its top bit is on the serial output before the first rising edge. A new byte is popped after every eighth rising edge.
- R9: A pop from an empty FIFO, local or serial, returns 0x00 and sets the sticky underflow flag.
- R10: A push into a full FIFO drops the byte and sets the sticky overflow flag. The bytes already held are kept.
- R11: The serial output enable is high only while the synchronized chip-select is low, and the serial output reads 0 while it is high.
- R12: The mode is sampled when chip-select falls, and modes 00 and 11 give configuration frames. A rising chip-select ends a stream and discards any partial byte.
- R13: The output enable rises on the second system clock edge after chip-select falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master |
| csn_i | input | 1 | Chip-select, active low |
| sdi_i | input | 1 | Serial data into the block |
| sdo_o | output | 1 | Serial data out of the block |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| mode_i | input | 2 | 01 burst transmit, 10 burst receive, other values configuration |
| push_i | input | 1 | Local push into the FIFO |
| push_data_i | input | 8 | Byte for a local push |
| pop_i | input | 1 | Local pop from the FIFO |
| pop_data_o | output | 8 | FIFO head, 0x00 when empty |
| fifo_empty_o | output | 1 | FIFO holds no byte |
| fifo_full_o | output | 1 | FIFO holds its full depth |
| fifo_ovf_o | output | 1 | Sticky overflow flag |
| fifo_unf_o | output | 1 | Sticky underflow flag |

## Verification
A change on a serial pin is visible two system clock edges later. The resulting action (a shift, a register write, a FIFO push or pop, a new output bit) happens on the third edge. A local push or pop shows on the flags and on the head one edge later. The bench holds each serial clock phase for 13 system cycles. It reads the serial output at the end of the low phase, just before it raises the clock, and it checks flags and pop data one full cycle after each local strobe. Bytes read back over the serial line go to a scoreboard, which compares them in order against the values the driver queued.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CFG  = 2'd1,
    ST_TXS  = 2'd2,
    ST_RXS  = 2'd3
  } ctlp_state_e;

  localparam logic [1:0] MODE_TX = 2'b01;
  localparam logic [1:0] MODE_RX = 2'b10;
endpackage

// File: rtl/ctlp_sync.sv
module ctlp_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ctlp_regfile.sv
module ctlp_regfile #(
  parameter int NREG = 25,
  parameter int AW   = 7,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] LAST = AW'(NREG - 1);

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NREG; i++)
        if (waddr == AW'(i)) mem[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (raddr == AW'(i)) rdata = mem[i];
  end

  // R6
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr > LAST) |-> (rdata == '0));
endmodule

// File: rtl/ctlp_fifo.sv
module ctlp_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full,
  output logic          ovf,
  output logic          unf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp, wp_n, rp_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          ovf_n, unf_n, do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = empty ? '0 : mem[rp];

  always_comb begin
    wp_n  = wp;
    rp_n  = rp;
    cnt_n = cnt;
    ovf_n = ovf | (push && full);
    unf_n = unf | (pop && empty);
    if (do_push) wp_n = (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
    if (do_pop)  rp_n = (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
    if (do_push && !do_pop) cnt_n = cnt + CW'(1);
    else if (do_pop && !do_push) cnt_n = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
      ovf <= ovf_n;
      unf <= unf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf);
  // R9
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) unf |=> unf);
  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH));
  // R10
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (full && ovf));
endmodule

// File: rtl/ctl_port_slave.sv
module ctl_port_slave
  import ctlp_pkg::*;
#(
  parameter int NREG       = 25,
  parameter int AW         = 7,
  parameter int DW         = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_i,
  input  logic          csn_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  input  logic [1:0]    mode_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          fifo_empty_o,
  output logic          fifo_full_o,
  output logic          fifo_ovf_o,
  output logic          fifo_unf_o
);
  localparam int FRAME_BITS = 1 + AW + DW;
  localparam int CW         = $clog2(FRAME_BITS + 1);
  localparam int BW         = $clog2(DW);
  localparam int SW         = (1 + AW > DW) ? 1 + AW : DW;

  logic [2:0]    syn;
  logic          cs_s, sclk_s, sdi_s, cs_d, sclk_d;
  logic          cs_act, cs_fall, sclk_rise, sclk_fall;
  ctlp_state_e   st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [SW-1:0] shin, shin_n, shin_adv;
  logic [AW:0]   cmd, cmd_n;
  logic [DW-1:0] shout, shout_n;
  logic          sdo_q, sdo_n;
  logic          ser_push, ser_pop, rf_we;
  logic [DW-1:0] rf_rdata, fifo_q;
  logic          f_push, f_pop;
  logic [DW-1:0] f_wdata;

  ctlp_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({csn_i, sclk_i, sdi_i}), .q(syn)
  );
  assign cs_s   = syn[2];
  assign sclk_s = syn[1];
  assign sdi_s  = syn[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_act    = !cs_s;
  assign cs_fall   = cs_d && !cs_s;
  assign sclk_rise = sclk_s && !sclk_d;
  assign sclk_fall = !sclk_s && sclk_d;
  assign shin_adv  = {shin[SW-2:0], sdi_s};

  always_comb begin
    st_n     = st;
    cnt_n    = cnt;
    shin_n   = shin;
    cmd_n    = cmd;
    shout_n  = shout;
    sdo_n    = sdo_q;
    ser_push = 1'b0;
    ser_pop  = 1'b0;
    rf_we    = 1'b0;
    if (!cs_act) begin
      st_n = ST_IDLE;
    end else if (cs_fall) begin
      cnt_n   = '0;
      shout_n = '0;
      sdo_n   = 1'b0;
      if (mode_i == MODE_TX) begin
        st_n = ST_TXS;
      end else if (mode_i == MODE_RX) begin
        st_n    = ST_RXS;
        ser_pop = 1'b1;
        sdo_n   = fifo_q[DW-1];
        shout_n = {fifo_q[DW-2:0], 1'b0};
      end else begin
        st_n = ST_CFG;
      end
    end else if (sclk_rise) begin
      shin_n = shin_adv;
      case (st)
        ST_CFG: begin
          if (cnt != CW'(FRAME_BITS)) cnt_n = cnt + CW'(1);
          if (cnt == CW'(AW)) begin
            cmd_n = shin_adv[AW:0];
            if (shin_adv[AW]) shout_n = rf_rdata;
          end
          if (cnt == CW'(FRAME_BITS - 1) && !cmd[AW]) rf_we = 1'b1;
        end
        ST_TXS: begin
          if (cnt[BW-1:0] == BW'(DW - 1)) begin
            cnt_n    = '0;
            ser_push = 1'b1;
          end else begin
            cnt_n = cnt + CW'(1);
          end
        end
        ST_RXS: begin
          if (cnt[BW-1:0] == BW'(DW - 1)) begin
            cnt_n   = '0;
            ser_pop = 1'b1;
            shout_n = fifo_q;
          end else begin
            cnt_n = cnt + CW'(1);
          end
        end
        default: ;
      endcase
    end else if (sclk_fall && st != ST_IDLE) begin
      sdo_n   = shout[DW-1];
      shout_n = {shout[DW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      shin  <= '0;
      cmd   <= '0;
      shout <= '0;
      sdo_q <= 1'b0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      shin  <= shin_n;
      cmd   <= cmd_n;
      shout <= shout_n;
      sdo_q <= sdo_n;
    end
  end

  ctlp_regfile #(.NREG(NREG), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(cmd[AW-1:0]),
    .wdata(shin_adv[DW-1:0]), .raddr(shin_adv[AW-1:0]), .rdata(rf_rdata)
  );

  assign f_push  = ser_push || (push_i && st != ST_TXS);
  assign f_pop   = ser_pop || (pop_i && st != ST_RXS);
  assign f_wdata = ser_push ? shin_adv[DW-1:0] : push_data_i;

  ctlp_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(f_push), .wdata(f_wdata), .pop(f_pop),
    .rdata(fifo_q), .empty(fifo_empty_o), .full(fifo_full_o),
    .ovf(fifo_ovf_o), .unf(fifo_unf_o)
  );

  assign pop_data_o = fifo_q;
  assign sdo_oe_o   = cs_act;
  assign sdo_o      = cs_act && sdo_q;

  // R11
  idle_when_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (st == ST_IDLE));
  // R7
  push_only_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_push |-> (st == ST_TXS && sclk_rise));
  // R3
  we_only_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (st == ST_CFG && cs_act && sclk_rise));
  // R8
  pop_only_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_pop |-> (st == ST_RXS || (cs_fall && mode_i == MODE_RX)));
endmodule

// File: tb/ctl_port_slave_test.sv
module ctl_port_slave_test;
  localparam int HALF  = 13;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       push = 1'b0, pop = 1'b0;
  logic [7:0] push_data = 8'h00;
  logic       sdo, sdo_oe, empty, full, ovf, unf;
  logic [7:0] pop_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] expq[$];
  string      tagq[$];
  logic [7:0] gotq[$];

  always #2 clk = ~clk;

  ctl_port_slave #(.FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .mode_i(mode), .push_i(push),
    .push_data_i(push_data), .pop_i(pop), .pop_data_o(pop_data),
    .fifo_empty_o(empty), .fifo_full_o(full), .fifo_ovf_o(ovf), .fifo_unf_o(unf)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic xbit(input logic b, output logic got);
    sdi = b;
    wait_cyc(HALF);
    got  = sdo;
    sclk = 1'b1;
    wait_cyc(HALF);
    sclk = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] o, output logic [7:0] i);
    logic g;
    for (int k = 7; k >= 0; k--) begin
      xbit(o[k], g);
      i[k] = g;
    end
  endtask

  task automatic cs_low();
    csn = 1'b0;
    wait_cyc(20);
  endtask

  task automatic cs_high();
    wait_cyc(HALF);
    csn = 1'b1;
    wait_cyc(20);
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    cs_low();
    xbyte({1'b0, a}, dummy);
    xbyte(d, dummy);
    cs_high();
  endtask

  task automatic reg_read(input logic [6:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] dummy, got;
    expq.push_back(exp);
    tagq.push_back(tag);
    cs_low();
    xbyte({1'b1, a}, dummy);
    xbyte(8'h00, got);
    cs_high();
    gotq.push_back(got);
  endtask

  task automatic lpush(input logic [7:0] v);
    push = 1'b1;
    push_data = v;
    wait_cyc(1);
    push = 1'b0;
    wait_cyc(1);
  endtask

  task automatic lpop(input logic [7:0] exp, input string tag);
    chk(tag, pop_data, exp);
    pop = 1'b1;
    wait_cyc(1);
    pop = 1'b0;
    wait_cyc(1);
  endtask

  // scoreboard monitor: compares each serially received byte with the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      if (gotq.size() != 0) begin
        logic [7:0] g;
        g = gotq.pop_front();
        if (expq.size() == 0) begin
          chk("scoreboard-unexpected", g, 32'hFFFF);
        end else begin
          logic [7:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(t, g, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] dummy, got;
    logic g;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);

    // R1 reset state
    chk("R1 oe", sdo_oe, 0);
    chk("R1 empty", empty, 1);
    chk("R1 ovf", ovf, 0);
    chk("R1 unf", unf, 0);
    reg_read(7'h05, 8'h00, "R1 reg05 reset");

    // R2 R3 R4 write and read back, including the last valid address
    reg_write(7'h03, 8'hA5);
    reg_write(7'h18, 8'h3C);
    reg_write(7'h00, 8'h81);
    reg_read(7'h03, 8'hA5, "R3 reg03");
    reg_read(7'h18, 8'h3C, "R2 reg18 boundary");
    reg_read(7'h00, 8'h81, "R4 reg00");

    // R6 out-of-range addresses
    reg_write(7'h19, 8'hFF);
    reg_write(7'h7F, 8'h11);
    reg_read(7'h19, 8'h00, "R6 reg19");
    reg_read(7'h7F, 8'h00, "R6 reg7F");
    reg_read(7'h18, 8'h3C, "R6 reg18 untouched");

    // R5 truncated frame after 15 bits
    cs_low();
    xbyte({1'b0, 7'h03}, dummy);
    for (int k = 0; k < 7; k++) xbit(1'b0, g);
    cs_high();
    reg_read(7'h03, 8'hA5, "R5 reg03 after short frame");

    // R13 R11 output enable timing
    csn = 1'b0;
    wait_cyc(1);
    chk("R13 oe one edge", sdo_oe, 0);
    wait_cyc(1);
    chk("R13 oe two edges", sdo_oe, 1);
    csn = 1'b1;
    wait_cyc(4);
    chk("R11 oe high cs", sdo_oe, 0);
    chk("R11 sdo zero", sdo, 0);
    wait_cyc(20);

    // R7 R12 burst transmit with a trailing partial byte
    mode = 2'b01;
    cs_low();
    xbyte(8'h11, dummy);
    xbyte(8'h22, dummy);
    push = 1'b1;
    push_data = 8'hEE;
    wait_cyc(1);
    push = 1'b0;
    xbyte(8'h33, dummy);
    for (int k = 0; k < 4; k++) xbit(1'b1, g);
    cs_high();
    mode = 2'b00;
    lpop(8'h11, "R7 byte0");
    lpop(8'h22, "R7 byte1");
    lpop(8'h33, "R7 byte2");
    chk("R12 partial dropped", empty, 1);
    reg_read(7'h11, 8'h00, "R12 stream not a write");

    // R9 local underflow
    lpop(8'h00, "R9 empty pop data");
    chk("R9 unf set", unf, 1);
    wait_cyc(5);
    chk("R9 unf sticky", unf, 1);

    // R8 R9 burst receive
    lpush(8'hC3);
    lpush(8'h5A);
    mode = 2'b10;
    cs_low();
    expq.push_back(8'hC3); tagq.push_back("R8 rx byte0");
    expq.push_back(8'h5A); tagq.push_back("R8 rx byte1");
    expq.push_back(8'h00); tagq.push_back("R9 rx empty byte");
    xbyte(8'h00, got); gotq.push_back(got);
    xbyte(8'h00, got); gotq.push_back(got);
    xbyte(8'h00, got); gotq.push_back(got);
    cs_high();
    mode = 2'b00;
    chk("R8 fifo drained", empty, 1);

    // R10 overflow
    for (int k = 0; k <= DEPTH; k++) lpush(8'h40 + 8'(k));
    chk("R10 full", full, 1);
    chk("R10 ovf", ovf, 1);
    for (int k = 0; k < DEPTH; k++) lpop(8'h40 + 8'(k), "R10 kept byte");
    chk("R10 extra dropped", empty, 1);

    // R12 mode 11 acts as configuration
    mode = 2'b11;
    reg_write(7'h07, 8'h5E);
    mode = 2'b00;
    reg_read(7'h07, 8'h5E, "R12 mode11 write");

    wait_cyc(10);
    if (expq.size() != 0) chk("scoreboard-leftover", expq.size(), 0);
    finish_run();
  end
endmodule